// File: doc/BRIEF.md
# Compact 8-bit Multi-Cycle Processor Core

This block is a small processor that executes a sixteen-operation instruction set on 8-bit data. Instructions are 20 bits wide and sit in an internal instruction store addressed by an 8-bit program counter. Operands come from a register file that holds a constant-zero register, five general registers and a stack pointer. Loads and stores use a 256-byte data store. Each instruction passes through a short sequence of states. A microprogrammed controller leads that sequence: a control-word table, indexed by the current state and the opcode, gives every datapath strobe and the next state.

The controller has five states. FETCH loads the instruction register from the location named by the program counter and always moves to DECODE. DECODE latches both source registers and always moves to EXEC. EXEC computes the ALU result and updates the program counter. From EXEC, arithmetic, logic and shift operations go to WB, a load goes to MEM, and a store, branch or jump goes back to FETCH. MEM reads the data store and moves to WB. WB writes the register file and returns to FETCH. Reset puts the controller in FETCH.

Both stores are filled through write ports while reset is held. A debug port reads any register and any data byte combinationally, and the program counter is visible as an output.

Top module: `mini_core`

## Requirements
- R1: An instruction word carries the opcode in bits 19:16. The R form has src1 in 15:12, src2 in 11:8, dst in 7:4 and the shift amount in 3:0. The I form has src1 in 15:12, src2 in 11:8 and an 8-bit immediate in 7:0. The J form has its target in 15:8. The opcodes are add=0, addi=1, sub=2, subi=3, and=4, andi=5, or=6, ori=7, sll=8, srl=9, nor=10, sw=11, lw=12, beq=13, bneq=14, j=15.
- R2: While reset is held, and right after it is released, the program counter is 0, registers 0 to 5 read 0 and register 6 (the stack pointer) reads 8'hFF.
- R3: ALU and shift operations take 4 cycles, lw takes 5, and sw, beq, bneq and j take 3. The program counter changes only at the end of the third cycle, and a register write lands at the end of the last cycle.
- R4: add, sub, and, or and nor write src1 op src2, modulo 256, to the register named by dst.
- R5: addi, subi, andi and ori write src1 op imm to the register named by src2. The immediate is zero-extended and the result is taken modulo 256.
- R6: sll and srl write src1 shifted left or right by the 4-bit shift amount to dst. An amount of 8 or more gives 0.
- R7: Register specifier 0 always reads 0, and writes to it have no effect. Specifiers 7 to 15 also read 0 and ignore writes. Specifiers 1 to 5 are the general registers.
- R8: lw writes the data byte at address src1+imm (modulo 256) to the register named by src2.
- R9: sw writes the value of the register named by src2 to the data byte at address src1+imm (modulo 256).
- R10: Specifier 6 is the stack pointer. It serves as a base register like any other, so an offset from it wraps past 8'hFF to 8'h00.
- R11: beq (when src1 equals src2) and bneq (when they differ) load the program counter with the 8-bit field in bits 7:0. When the condition fails, the program counter increments by one.
- R12: j loads the program counter with bits 15:8.
- R13: dbg_reg_data shows the register chosen by dbg_reg_sel, and dbg_mem_data shows the data byte at dbg_mem_addr. Both follow their select inputs with no clock delay.
- R14: imem_we and dmem_we write the instruction and data stores at the next rising edge. An external data write takes priority over a store from the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | 8 | Instruction store write address |
| imem_wdata | input | 20 | Instruction word to write |
| dmem_we | input | 1 | Data store write enable |
| dmem_waddr | input | 8 | Data store write address |
| dmem_wdata | input | 8 | Data byte to write |
| dbg_reg_sel | input | 4 | Register specifier to observe |
| dbg_reg_data | output | 8 | Value of the selected register |
| dbg_mem_addr | input | 8 | Data store address to observe |
| dbg_mem_data | output | 8 | Data byte at dbg_mem_addr |
| pc_out | output | 8 | Current program counter |

## Verification
The bench builds the core with its defaults: 256 instruction words, 256 data bytes, seven register slots and a stack pointer that resets to 8'hFF. With full 8-bit address spaces, stack-relative offsets wrap past the top of data memory. Every branch target in the 8-bit field can be reached, and a jump to its own address serves as a stable halt point. That halt point lets whole random programs run to completion and be compared, register by register and byte by byte, against a reference model in the bench.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int INSTR_W = 20;
    localparam int OP_W    = 4;
    localparam int RSEL_W  = 4;
    localparam int STATE_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDI = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBI = 4'd3,
        OP_AND  = 4'd4,
        OP_ANDI = 4'd5,
        OP_OR   = 4'd6,
        OP_ORI  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_NOR  = 4'd10,
        OP_SW   = 4'd11,
        OP_LW   = 4'd12,
        OP_BEQ  = 4'd13,
        OP_BNE  = 4'd14,
        OP_J    = 4'd15
    } opcode_e;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEM    = 3'd3,
        ST_WB     = 3'd4
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLL, ALU_SRL
    } alu_op_e;

    typedef enum logic [2:0] {
        PC_HOLD, PC_INC, PC_JUMP, PC_BEQ, PC_BNE
    } pc_mode_e;

    typedef struct packed {
        state_e   nxt;
        logic     ir_ld;
        logic     opnd_ld;
        logic     res_ld;
        logic     b_imm;
        alu_op_e  alu_op;
        pc_mode_e pc_mode;
        logic     mem_we;
        logic     mdr_ld;
        logic     rf_we;
        logic     wb_mdr;
        logic     dst_rtype;
    } ctrl_word_t;

    function automatic logic is_rtype(opcode_e op);
        return op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOR, OP_SLL, OP_SRL};
    endfunction

endpackage

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [3:0]    shamt,
    output logic [DW-1:0] y
);

    localparam logic [3:0] SH_LIMIT = 4'(DW);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_SLL: y = (shamt >= SH_LIMIT) ? '0 : (a << shamt);
            ALU_SRL: y = (shamt >= SH_LIMIT) ? '0 : (a >> shamt);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/core_regfile.sv
module core_regfile
    import core_pkg::*;
#(
    parameter int              DW       = DATA_W,
    parameter int              NUM_REGS = 7,
    parameter int              SP_IDX   = 6,
    parameter logic [DW-1:0]   SP_RESET = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RSEL_W-1:0] ra1,
    input  logic [RSEL_W-1:0] ra2,
    input  logic [RSEL_W-1:0] ra3,
    output logic [DW-1:0]     rd1,
    output logic [DW-1:0]     rd2,
    output logic [DW-1:0]     rd3,
    input  logic              we,
    input  logic [RSEL_W-1:0] wa,
    input  logic [DW-1:0]     wd
);

    // slot 0 is the constant-zero register and has no storage
    logic [NUM_REGS-1:1][DW-1:0] regs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 1; k < NUM_REGS; k++)
                regs[k] <= (k == SP_IDX) ? SP_RESET : '0;
        end else if (we) begin
            for (int k = 1; k < NUM_REGS; k++)
                if (wa == RSEL_W'(k)) regs[k] <= wd;
        end
    end

    always_comb begin
        rd1 = '0;
        rd2 = '0;
        rd3 = '0;
        for (int k = 1; k < NUM_REGS; k++) begin
            if (ra1 == RSEL_W'(k)) rd1 = regs[k];
            if (ra2 == RSEL_W'(k)) rd2 = regs[k];
            if (ra3 == RSEL_W'(k)) rd3 = regs[k];
        end
    end

    // R7: a write aimed at the zero slot or an unused specifier leaves storage untouched
    p_dead_dst_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || wa == '0 || wa >= RSEL_W'(NUM_REGS)) |=> $stable(regs));

endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
    import core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  opcode_e    op,
    output state_e     state,
    output ctrl_word_t cw
);

    localparam int UROM_DEPTH = 2 ** (STATE_W + OP_W);

    function automatic ctrl_word_t micro_word(state_e s, opcode_e o);
        ctrl_word_t w;
        w         = '0;
        w.nxt     = ST_FETCH;
        w.alu_op  = ALU_ADD;
        w.pc_mode = PC_HOLD;
        unique case (s)
            ST_FETCH: begin
                w.ir_ld = 1'b1;
                w.nxt   = ST_DECODE;
            end
            ST_DECODE: begin
                w.opnd_ld = 1'b1;
                w.nxt     = ST_EXEC;
            end
            ST_EXEC: begin
                w.res_ld  = 1'b1;
                w.pc_mode = PC_INC;
                w.nxt     = ST_WB;
                unique case (o)
                    OP_ADD:  w.alu_op = ALU_ADD;
                    OP_ADDI: begin w.alu_op = ALU_ADD; w.b_imm = 1'b1; end
                    OP_SUB:  w.alu_op = ALU_SUB;
                    OP_SUBI: begin w.alu_op = ALU_SUB; w.b_imm = 1'b1; end
                    OP_AND:  w.alu_op = ALU_AND;
                    OP_ANDI: begin w.alu_op = ALU_AND; w.b_imm = 1'b1; end
                    OP_OR:   w.alu_op = ALU_OR;
                    OP_ORI:  begin w.alu_op = ALU_OR;  w.b_imm = 1'b1; end
                    OP_SLL:  w.alu_op = ALU_SLL;
                    OP_SRL:  w.alu_op = ALU_SRL;
                    OP_NOR:  w.alu_op = ALU_NOR;
                    OP_SW:   begin w.b_imm = 1'b1; w.mem_we = 1'b1; w.nxt = ST_FETCH; end
                    OP_LW:   begin w.b_imm = 1'b1; w.nxt = ST_MEM; end
                    OP_BEQ:  begin w.pc_mode = PC_BEQ;  w.nxt = ST_FETCH; end
                    OP_BNE:  begin w.pc_mode = PC_BNE;  w.nxt = ST_FETCH; end
                    OP_J:    begin w.pc_mode = PC_JUMP; w.nxt = ST_FETCH; end
                    default: w.nxt = ST_FETCH;
                endcase
            end
            ST_MEM: begin
                w.mdr_ld = 1'b1;
                w.nxt    = ST_WB;
            end
            ST_WB: begin
                w.rf_we     = 1'b1;
                w.wb_mdr    = (o == OP_LW);
                w.dst_rtype = is_rtype(o);
            end
            default: w.nxt = ST_FETCH;
        endcase
        return w;
    endfunction

    // control store, one word per (state, opcode) pair, built at elaboration
    ctrl_word_t urom [UROM_DEPTH];

    for (genvar g = 0; g < UROM_DEPTH; g++) begin : g_urom
        assign urom[g] = micro_word(state_e'(3'(g >> OP_W)), opcode_e'(4'(g & 15)));
    end

    state_e state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= cw.nxt;
    end

    always_comb begin
        cw = urom[{state_q, op}];
    end

    assign state = state_q;

    // R3: fetch is always followed by decode, and decode by execute
    p_fetch_then_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE));
    p_decode_then_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |=> (state_q == ST_EXEC));

endmodule

// File: rtl/mini_core.sv
module mini_core
    import core_pkg::*;
#(
    parameter int          IMEM_DEPTH = 256,
    parameter int          DMEM_DEPTH = 256,
    parameter int          NUM_REGS   = 7,
    parameter logic [7:0]  SP_RESET   = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        imem_we,
    input  logic [7:0]  imem_waddr,
    input  logic [19:0] imem_wdata,
    input  logic        dmem_we,
    input  logic [7:0]  dmem_waddr,
    input  logic [7:0]  dmem_wdata,
    input  logic [3:0]  dbg_reg_sel,
    output logic [7:0]  dbg_reg_data,
    input  logic [7:0]  dbg_mem_addr,
    output logic [7:0]  dbg_mem_data,
    output logic [7:0]  pc_out
);

    localparam int IA_W   = $clog2(IMEM_DEPTH);
    localparam int DA_W   = $clog2(DMEM_DEPTH);
    localparam int SP_IDX = NUM_REGS - 1;

    logic [INSTR_W-1:0] imem [IMEM_DEPTH];
    logic [DATA_W-1:0]  dmem [DMEM_DEPTH];

    logic [ADDR_W-1:0]  pc_q, pc_nxt;
    logic [INSTR_W-1:0] ir_q;
    logic [DATA_W-1:0]  a_q, b_q, res_q, mdr_q;
    logic [DATA_W-1:0]  rd1, rd2, alu_b, alu_y, wb_data;
    logic [RSEL_W-1:0]  wb_addr;
    opcode_e            op;
    state_e             state;
    ctrl_word_t         cw;

    assign op = opcode_e'(ir_q[19:16]);

    core_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .state (state),
        .cw    (cw)
    );

    assign wb_addr = cw.dst_rtype ? ir_q[7:4] : ir_q[11:8];
    assign wb_data = cw.wb_mdr ? mdr_q : res_q;

    core_regfile #(
        .DW       (DATA_W),
        .NUM_REGS (NUM_REGS),
        .SP_IDX   (SP_IDX),
        .SP_RESET (SP_RESET)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (ir_q[15:12]),
        .ra2   (ir_q[11:8]),
        .ra3   (dbg_reg_sel),
        .rd1   (rd1),
        .rd2   (rd2),
        .rd3   (dbg_reg_data),
        .we    (cw.rf_we),
        .wa    (wb_addr),
        .wd    (wb_data)
    );

    assign alu_b = cw.b_imm ? ir_q[7:0] : b_q;

    core_alu #(.DW(DATA_W)) u_alu (
        .op    (cw.alu_op),
        .a     (a_q),
        .b     (alu_b),
        .shamt (ir_q[3:0]),
        .y     (alu_y)
    );

    always_comb begin
        unique case (cw.pc_mode)
            PC_HOLD: pc_nxt = pc_q;
            PC_INC:  pc_nxt = pc_q + 1'b1;
            PC_JUMP: pc_nxt = ir_q[15:8];
            PC_BEQ:  pc_nxt = (a_q == b_q) ? ir_q[7:0] : pc_q + 1'b1;
            PC_BNE:  pc_nxt = (a_q != b_q) ? ir_q[7:0] : pc_q + 1'b1;
            default: pc_nxt = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
            mdr_q <= '0;
        end else begin
            if (cw.ir_ld)   ir_q  <= imem[IA_W'(pc_q)];
            if (cw.opnd_ld) begin
                a_q <= rd1;
                b_q <= rd2;
            end
            if (cw.res_ld)  res_q <= alu_y;
            if (cw.mdr_ld)  mdr_q <= dmem[DA_W'(res_q)];
            pc_q <= pc_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (imem_we) imem[IA_W'(imem_waddr)] <= imem_wdata;
    end

    // loader writes win over a store from the core
    always_ff @(posedge clk) begin
        if (dmem_we)         dmem[DA_W'(dmem_waddr)] <= dmem_wdata;
        else if (cw.mem_we)  dmem[DA_W'(alu_y)]      <= b_q;
    end

    assign dbg_mem_data = dmem[DA_W'(dbg_mem_addr)];
    assign pc_out       = pc_q;

    // R3: the program counter moves only at the end of the execute state
    p_pc_only_in_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EXEC) |=> (pc_q == $past(pc_q)));

    // R3: register file writes happen only in write-back
    p_rf_write_in_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cw.rf_we |-> (state == ST_WB));

    // R9: the core stores to data memory only while executing sw
    p_store_only_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cw.mem_we |-> (state == ST_EXEC && op == OP_SW));

    // R11: a taken beq lands on the 8-bit field
    p_beq_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && op == OP_BEQ && a_q == b_q) |=> (pc_q == $past(ir_q[7:0])));

    // R12: a jump lands on its target field
    p_jump_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && op == OP_J) |=> (pc_q == $past(ir_q[15:8])));

    // R6: a shift by 8 or more leaves a zero result
    p_big_shift_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && (op == OP_SLL || op == OP_SRL) && ir_q[3]) |=> (res_q == '0));

endmodule

// File: tb/mini_core_test.sv
module mini_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [7:0]  imem_waddr = '0;
    logic [19:0] imem_wdata = '0;
    logic        dmem_we = 1'b0;
    logic [7:0]  dmem_waddr = '0;
    logic [7:0]  dmem_wdata = '0;
    logic [3:0]  dbg_reg_sel = '0;
    logic [7:0]  dbg_reg_data;
    logic [7:0]  dbg_mem_addr = '0;
    logic [7:0]  dbg_mem_data;
    logic [7:0]  pc_out;

    always #5 clk = ~clk;

    mini_core uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .imem_we      (imem_we),
        .imem_waddr   (imem_waddr),
        .imem_wdata   (imem_wdata),
        .dmem_we      (dmem_we),
        .dmem_waddr   (dmem_waddr),
        .dmem_wdata   (dmem_wdata),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_mem_data (dbg_mem_data),
        .pc_out       (pc_out)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    logic [19:0] prog  [256];
    logic [7:0]  m_mem [256];
    logic [7:0]  m_reg [16];
    logic [7:0]  m_pc;

    // R1 encodings
    function automatic logic [19:0] enc_r(int op, int s1, int s2, int d, int sh);
        return {4'(op), 4'(s1), 4'(s2), 4'(d), 4'(sh)};
    endfunction
    function automatic logic [19:0] enc_i(int op, int s1, int s2, int imm);
        return {4'(op), 4'(s1), 4'(s2), 8'(imm)};
    endfunction
    function automatic logic [19:0] enc_j(int tgt);
        return {4'd15, 8'(tgt), 8'h00};
    endfunction

    function automatic logic [7:0] rr(logic [3:0] i);
        return (i >= 1 && i <= 6) ? m_reg[i] : 8'h00;
    endfunction

    task automatic wreg(logic [3:0] i, logic [7:0] v);
        if (i >= 1 && i <= 6) m_reg[i] = v;
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = enc_j(i);
    endtask

    task automatic random_mem();
        for (int i = 0; i < 256; i++) m_mem[i] = 8'($urandom);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
        m_reg[6] = 8'hFF;
        m_pc = 8'h00;
    endtask

    // reference model built from the requirements
    task automatic model_run();
        for (int step = 0; step < 2000; step++) begin
            logic [19:0] w;
            logic [3:0]  op, s1, s2, d, sh;
            logic [7:0]  imm, a, b, nxt;
            w   = prog[m_pc];
            op  = w[19:16]; s1 = w[15:12]; s2 = w[11:8]; d = w[7:4]; sh = w[3:0];
            imm = w[7:0];
            a   = rr(s1);
            b   = rr(s2);
            nxt = m_pc + 8'd1;
            case (op)
                4'd0:  wreg(d, a + b);
                4'd1:  wreg(s2, a + imm);
                4'd2:  wreg(d, a - b);
                4'd3:  wreg(s2, a - imm);
                4'd4:  wreg(d, a & b);
                4'd5:  wreg(s2, a & imm);
                4'd6:  wreg(d, a | b);
                4'd7:  wreg(s2, a | imm);
                4'd8:  wreg(d, (sh >= 4'd8) ? 8'h00 : 8'(a << sh));
                4'd9:  wreg(d, (sh >= 4'd8) ? 8'h00 : 8'(a >> sh));
                4'd10: wreg(d, ~(a | b));
                4'd11: m_mem[8'(a + imm)] = b;
                4'd12: wreg(s2, m_mem[8'(a + imm)]);
                4'd13: if (a == b) nxt = imm;
                4'd14: if (a != b) nxt = imm;
                default: begin
                    if (w[15:8] == m_pc) return;
                    nxt = w[15:8];
                end
            endcase
            m_pc = nxt;
        end
    endtask

    // R14: both stores are loaded while reset is held
    task automatic boot();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            imem_we    = 1'b1;
            imem_waddr = 8'(i);
            imem_wdata = prog[i];
            dmem_we    = 1'b1;
            dmem_waddr = 8'(i);
            dmem_wdata = m_mem[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        dmem_we = 1'b0;
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic reg_rd(int r, output logic [7:0] v);
        dbg_reg_sel = 4'(r);
        #1;
        v = dbg_reg_data;
    endtask

    task automatic mem_rd(int a, output logic [7:0] v);
        dbg_mem_addr = 8'(a);
        #1;
        v = dbg_mem_data;
    endtask

    task automatic check_reg(string tag, int r, logic [7:0] exp);
        logic [7:0] v;
        reg_rd(r, v);
        check($sformatf("%s reg%0d", tag, r), v, exp);
    endtask

    // R13: every register and every byte read back through the debug port
    task automatic compare_all(string tag);
        logic [7:0] v;
        int mism;
        for (int r = 0; r < 8; r++) check_reg(tag, r, rr(4'(r)));
        check({tag, " pc"}, pc_out, m_pc);
        mism = 0;
        for (int i = 0; i < 256; i++) begin
            mem_rd(i, v);
            if (v !== m_mem[i]) mism++;
        end
        check({tag, " mem mismatches"}, mism, 0);
    endtask

    task automatic run_and_compare(string tag);
        boot();
        model_run();
        repeat (300) @(negedge clk);
        compare_all(tag);
    endtask

    task automatic gen_random(int n);
        clear_prog();
        for (int i = 0; i < n; i++) begin
            int op, s1, s2, d, sh, imm, tgt;
            op  = int'($urandom % 16);
            s1  = ($urandom % 8 == 0) ? int'($urandom % 16) : int'($urandom % 7);
            s2  = int'($urandom % 8);
            d   = int'($urandom % 8);
            sh  = int'($urandom % 16);
            imm = int'($urandom % 256);
            tgt = i + 1 + int'($urandom % 3);
            if (tgt > n) tgt = n;
            if (op == 15)                               prog[i] = enc_j(tgt);
            else if (op == 13 || op == 14)              prog[i] = enc_i(op, s1, s2, tgt);
            else if (op inside {0, 2, 4, 6, 8, 9, 10})  prog[i] = enc_r(op, s1, s2, d, sh);
            else                                        prog[i] = enc_i(op, s1, s2, imm);
        end
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'h1D5E_0A11));

        // directed: reset values and per-cycle timing
        clear_prog();
        prog[0] = enc_i(1, 0, 1, 5);      // addi t0, zero, 5
        prog[1] = enc_i(12, 1, 2, 3);     // lw t1, 3(t0) -> address 8
        prog[2] = enc_i(11, 6, 1, 1);     // sw t0, 1(sp) -> address 0 after wrap
        prog[3] = enc_j(3);
        random_mem();
        m_mem[0] = 8'hA5;
        m_mem[8] = 8'h3C;
        boot();
        check("R2 reset pc", pc_out, 8'h00);
        for (int r = 0; r < 6; r++) check_reg("R2 reset", r, 8'h00);
        check_reg("R2 reset sp", 6, 8'hFF);
        repeat (2) @(negedge clk);
        check("R3 pc before exec", pc_out, 8'h00);
        @(negedge clk);
        check("R3 pc after exec", pc_out, 8'h01);
        check_reg("R3 no write before wb", 1, 8'h00);
        @(negedge clk);
        check_reg("R5 addi result", 1, 8'h05);
        repeat (4) @(negedge clk);
        check_reg("R8 lw before wb", 2, 8'h00);
        @(negedge clk);
        check_reg("R8 lw result", 2, 8'h3C);
        check("R3 pc after lw", pc_out, 8'h02);
        repeat (2) @(negedge clk);
        mem_rd(0, v);
        check("R9 byte before store", v, 8'hA5);
        @(negedge clk);
        mem_rd(0, v);
        check("R10 sp offset wraps, R9 store", v, 8'h05);
        check("R3 pc after sw", pc_out, 8'h03);
        model_run();
        repeat (20) @(negedge clk);
        compare_all("R9 directed memory");

        // directed: shifts at and beyond the width
        clear_prog();
        prog[0] = enc_i(7, 0, 1, 8'h81);  // ori t0, zero, 0x81
        prog[1] = enc_r(8, 1, 0, 2, 1);   // sll t1, t0, 1
        prog[2] = enc_r(9, 1, 0, 3, 7);   // srl t2, t0, 7
        prog[3] = enc_r(8, 1, 0, 4, 8);   // sll t3, t0, 8
        prog[4] = enc_r(9, 1, 0, 5, 15);  // srl t4, t0, 15
        prog[5] = enc_j(5);
        random_mem();
        run_and_compare("R6 shifts");
        check_reg("R6 sll by 1", 2, 8'h02);
        check_reg("R6 srl by 7", 3, 8'h01);
        check_reg("R6 sll by 8", 4, 8'h00);
        check_reg("R6 srl by 15", 5, 8'h00);

        // directed: logic and arithmetic forms
        clear_prog();
        prog[0] = enc_i(7, 0, 1, 8'hF0);  // ori t0, zero, 0xF0
        prog[1] = enc_i(5, 1, 2, 8'h3C);  // andi t1, t0, 0x3C
        prog[2] = enc_r(10, 1, 2, 3, 0);  // nor t2, t0, t1
        prog[3] = enc_r(2, 2, 1, 4, 0);   // sub t3, t1, t0
        prog[4] = enc_i(3, 0, 5, 1);      // subi t4, zero, 1
        prog[5] = enc_r(0, 5, 5, 1, 0);   // add t0, t4, t4
        prog[6] = enc_j(6);
        random_mem();
        run_and_compare("R4 R5 alu");
        check_reg("R5 andi", 2, 8'h30);
        check_reg("R4 nor", 3, 8'h0F);
        check_reg("R4 sub wraps", 4, 8'h40);
        check_reg("R5 subi wraps", 5, 8'hFF);
        check_reg("R4 add wraps", 1, 8'hFE);

        // directed: zero register and unused specifiers
        clear_prog();
        prog[0] = enc_i(1, 0, 0, 9);      // addi zero, zero, 9
        prog[1] = enc_i(1, 0, 9, 7);      // addi r9, zero, 7
        prog[2] = enc_i(1, 0, 1, 3);      // addi t0, zero, 3
        prog[3] = enc_r(0, 9, 1, 2, 0);   // add t1, r9, t0
        prog[4] = enc_i(1, 1, 7, 4);      // addi r7, t0, 4
        prog[5] = enc_j(5);
        random_mem();
        run_and_compare("R7 zero");
        check_reg("R7 zero stays zero", 0, 8'h00);
        check_reg("R7 spec 9 reads zero", 9, 8'h00);
        check_reg("R7 spec 7 reads zero", 7, 8'h00);
        check_reg("R7 sum uses zero", 2, 8'h03);
        check_reg("R10 sp untouched", 6, 8'hFF);

        // directed: branch and jump
        clear_prog();
        prog[0]  = enc_i(1, 0, 1, 4);     // addi t0, zero, 4
        prog[1]  = enc_i(1, 0, 2, 4);     // addi t1, zero, 4
        prog[2]  = enc_i(13, 1, 2, 5);    // beq t0, t1, 5 (taken)
        prog[3]  = enc_i(1, 0, 3, 8'h11); // skipped
        prog[5]  = enc_i(14, 1, 2, 8);    // bneq t0, t1, 8 (falls through)
        prog[6]  = enc_i(1, 0, 4, 8'h22); // addi t3, zero, 0x22
        prog[7]  = enc_j(9);
        prog[8]  = enc_i(1, 0, 5, 8'h33); // skipped
        prog[9]  = enc_i(14, 1, 0, 12);   // bneq t0, zero, 12 (taken)
        prog[10] = enc_i(1, 0, 3, 8'h44); // skipped
        prog[12] = enc_i(13, 1, 0, 14);   // beq t0, zero, 14 (falls through)
        prog[13] = enc_j(13);
        random_mem();
        run_and_compare("R11 R12 branches");
        check_reg("R11 beq taken skips", 3, 8'h00);
        check_reg("R11 bneq not taken runs next", 4, 8'h22);
        check_reg("R12 jump skips", 5, 8'h00);
        check("R11 final pc", pc_out, 8'd13);

        // constrained random programs, forward control flow only
        for (int t = 0; t < 12; t++) begin
            gen_random(24);
            random_mem();
            run_and_compare($sformatf("R1 R4 R5 R8 R9 R11 random%0d", t));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

endmodule